// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block decides, on every clock, which of several hardware threads hands the next instruction to a shared pipeline. It holds a program counter for each thread and takes a stall flag per thread. The selected thread number, that thread's PC and a valid flag are combinational outputs of the registered selection state and the current stall inputs. Each thread has its own PC, so changing thread needs no save or restore.

A mode input picks one of two policies. In the interleaving policy, the block moves to a new thread on each cycle, in ascending round-robin order, and passes over stalled threads. In the blocking policy, the block stays on one thread until that thread signals a long-latency stall event, such as a miss in the second-level cache. It then moves to the next eligible thread and holds valid low for a fixed refill penalty while the pipeline refills. PC update inputs load a branch target or advance a thread by one instruction. A branch update wins over an advance to the same thread.

Top module: `thread_issue_sel`

## Requirements
- R1: While reset is asserted, every thread PC loads `reset_vector`. The first issue after reset, in either mode, is thread 0 at that PC.
- R2: In interleave mode (`coarse_mode`=0) with no stalls, the selected thread advances by one each cycle in ascending order and wraps from NUM_THREADS-1 to 0.
- R3: In interleave mode, the search starts after the last issued thread and passes over every thread whose `stall_vec` bit is 1. `sel_valid` is 1 only for a non-stalled thread.
- R4: When every `stall_vec` bit is 1, `sel_valid` is 0 and the round-robin position holds. The next issue is the first free thread after the last one issued.
- R5: In blocking mode (`coarse_mode`=1), the selected thread stays the same from cycle to cycle. A `stall_vec` bit set for that thread without its `costly_vec` bit gives a bubble (`sel_valid`=0) with no change of thread.
- R6: In blocking mode, a `costly_vec` bit set for the current thread moves selection to the next thread in round-robin order whose stall and costly bits are both 0. `sel_valid` stays 0 for REFILL_CYCLES cycles, counting the event cycle, and the new thread issues on the cycle after that.
- R7: In blocking mode, a costly event with no eligible other thread keeps the current thread, gives `sel_valid`=0 for that cycle and inserts no refill penalty.
- R8: `sel_pc` is the PC of the selected thread. An advance (`adv_en`) adds INSN_BYTES to thread `adv_tid`, and a branch (`br_en`) loads `br_pc` into thread `br_tid`, both visible from the next cycle. A branch wins over an advance to the same thread, and other threads keep their PCs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_mode | input | 1 | 0 interleave policy, 1 blocking policy |
| reset_vector | input | PC_W | PC loaded into every thread during reset |
| stall_vec | input | NUM_THREADS | Per-thread stall flag, bit i for thread i |
| costly_vec | input | NUM_THREADS | Per-thread long-latency stall event, bit i for thread i |
| br_en | input | 1 | Load a branch target |
| br_tid | input | TID_W | Thread the branch target goes to |
| br_pc | input | PC_W | Branch target |
| adv_en | input | 1 | Advance one thread by INSN_BYTES |
| adv_tid | input | TID_W | Thread to advance |
| sel_valid | output | 1 | An instruction is issued this cycle |
| sel_tid | output | TID_W | Selected thread |
| sel_pc | output | PC_W | PC of the selected thread |

## Verification
The selection outputs depend on the stall and costly inputs of the same cycle, so each cycle's expected thread, valid and PC belong to the cycle in which the inputs are applied. PC updates and the round-robin position take effect one edge later. In a refill, the new thread is due REFILL_CYCLES cycles after the event cycle. The driver applies inputs just after a rising edge and queues the expectation from a model of the requirements. The monitor compares the outputs at the following falling edge, and PC and thread are compared only in cycles where an issue is expected.

// File: rtl/thread_issue_sel_pkg.sv
package thread_issue_sel_pkg;
   typedef enum logic {
      POLICY_INTERLEAVE = 1'b0,
      POLICY_BLOCKING   = 1'b1
   } policy_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/thread_issue_rr_pick.sv
module thread_issue_rr_pick #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = $clog2(NUM_THREADS)
) (
   input  logic [TID_W-1:0]       base,
   input  logic [NUM_THREADS-1:0] eligible,
   output logic                   found,
   output logic [TID_W-1:0]       pick
);
   import thread_issue_sel_pkg::*;

   localparam bit POW2 = is_pow2(NUM_THREADS);

   logic [TID_W-1:0] cand [1:NUM_THREADS];

   for (genvar k = 1; k <= NUM_THREADS; k++) begin : g_cand
      logic [TID_W:0] sum;
      assign sum = {1'b0, base} + (TID_W+1)'(k);
      if (POW2) begin : g_trunc
         assign cand[k] = sum[TID_W-1:0];
      end else begin : g_sub
         logic [TID_W:0] red;
         assign red     = (sum >= (TID_W+1)'(NUM_THREADS)) ? sum - (TID_W+1)'(NUM_THREADS) : sum;
         assign cand[k] = red[TID_W-1:0];
      end
   end

   always_comb begin
      found = 1'b0;
      pick  = base;
      for (int k = NUM_THREADS; k >= 1; k--) begin
         if (eligible[cand[k]]) begin
            found = 1'b1;
            pick  = cand[k];
         end
      end
   end
endmodule

// File: rtl/thread_issue_pc_bank.sv
module thread_issue_pc_bank #(
   parameter int NUM_THREADS = 4,
   parameter int PC_W        = 32,
   parameter int INSN_BYTES  = 4,
   parameter int TID_W       = $clog2(NUM_THREADS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PC_W-1:0]  reset_vector,
   input  logic             br_en,
   input  logic [TID_W-1:0] br_tid,
   input  logic [PC_W-1:0]  br_pc,
   input  logic             adv_en,
   input  logic [TID_W-1:0] adv_tid,
   input  logic [TID_W-1:0] rd_tid,
   output logic [PC_W-1:0]  rd_pc
);
   logic [PC_W-1:0] pc_q [NUM_THREADS];

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
      logic hit_br, hit_adv;
      assign hit_br  = br_en  && (br_tid  == TID_W'(t));
      assign hit_adv = adv_en && (adv_tid == TID_W'(t));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pc_q[t] <= reset_vector;
         else if (hit_br)  pc_q[t] <= br_pc;
         else if (hit_adv) pc_q[t] <= pc_q[t] + PC_W'(INSN_BYTES);
      end
   end

   always_comb begin
      rd_pc = pc_q[0];
      for (int t = 0; t < NUM_THREADS; t++) begin
         if (rd_tid == TID_W'(t)) rd_pc = pc_q[t];
      end
   end
endmodule

// File: rtl/thread_issue_policy.sv
module thread_issue_policy #(
   parameter int NUM_THREADS   = 4,
   parameter int REFILL_CYCLES = 3,
   parameter int TID_W         = $clog2(NUM_THREADS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   coarse_mode,
   input  logic [NUM_THREADS-1:0] stall_vec,
   input  logic [NUM_THREADS-1:0] costly_vec,
   output logic                   sel_valid,
   output logic [TID_W-1:0]       sel_tid
);
   import thread_issue_sel_pkg::*;

   localparam int CNT_W = $clog2(REFILL_CYCLES + 1);
   localparam logic [CNT_W-1:0] REFILL_LOAD = CNT_W'(REFILL_CYCLES - 1);

   logic [TID_W-1:0] owner_q, owner_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             fresh_q;
   logic [TID_W-1:0] fine_base;
   logic             fine_found, blk_found;
   logic [TID_W-1:0] fine_pick, blk_pick;
   policy_e          policy;

   assign policy    = policy_e'(coarse_mode);
   assign fine_base = fresh_q ? TID_W'(NUM_THREADS - 1) : owner_q;

   thread_issue_rr_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_pick_fine (
      .base(fine_base), .eligible(~stall_vec), .found(fine_found), .pick(fine_pick));

   thread_issue_rr_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_pick_blk (
      .base(owner_q), .eligible(~stall_vec & ~costly_vec), .found(blk_found), .pick(blk_pick));

   always_comb begin
      owner_d   = owner_q;
      cnt_d     = cnt_q;
      sel_valid = 1'b0;
      sel_tid   = owner_q;
      if (policy == POLICY_INTERLEAVE) begin
         cnt_d = '0;
         if (fine_found) begin
            sel_valid = 1'b1;
            sel_tid   = fine_pick;
            owner_d   = fine_pick;
         end
      end else if (cnt_q != '0) begin
         cnt_d = cnt_q - 1'b1;
      end else if (costly_vec[owner_q]) begin
         if (blk_found) begin
            owner_d = blk_pick;
            cnt_d   = REFILL_LOAD;
         end
      end else begin
         sel_valid = !stall_vec[owner_q];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= '0;
         cnt_q   <= '0;
         fresh_q <= 1'b1;
      end else begin
         owner_q <= owner_d;
         cnt_q   <= cnt_d;
         if (sel_valid) fresh_q <= 1'b0;
      end
   end
endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel #(
   parameter int NUM_THREADS   = 4,
   parameter int PC_W          = 32,
   parameter int INSN_BYTES    = 4,
   parameter int REFILL_CYCLES = 3,
   parameter int TID_W         = $clog2(NUM_THREADS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   coarse_mode,
   input  logic [PC_W-1:0]        reset_vector,
   input  logic [NUM_THREADS-1:0] stall_vec,
   input  logic [NUM_THREADS-1:0] costly_vec,
   input  logic                   br_en,
   input  logic [TID_W-1:0]       br_tid,
   input  logic [PC_W-1:0]        br_pc,
   input  logic                   adv_en,
   input  logic [TID_W-1:0]       adv_tid,
   output logic                   sel_valid,
   output logic [TID_W-1:0]       sel_tid,
   output logic [PC_W-1:0]        sel_pc
);
   if (NUM_THREADS < 2) begin : g_bad_threads
      $error("NUM_THREADS must be at least 2");
   end
   if (TID_W != $clog2(NUM_THREADS)) begin : g_bad_tid
      $error("TID_W must equal clog2(NUM_THREADS)");
   end
   if (REFILL_CYCLES < 1) begin : g_bad_refill
      $error("REFILL_CYCLES must be at least 1");
   end
   if (PC_W < 2 || INSN_BYTES < 1) begin : g_bad_pc
      $error("PC_W and INSN_BYTES out of range");
   end

   thread_issue_policy #(
      .NUM_THREADS(NUM_THREADS), .REFILL_CYCLES(REFILL_CYCLES), .TID_W(TID_W)
   ) u_policy (
      .clk(clk), .rst_n(rst_n), .coarse_mode(coarse_mode),
      .stall_vec(stall_vec), .costly_vec(costly_vec),
      .sel_valid(sel_valid), .sel_tid(sel_tid));

   thread_issue_pc_bank #(
      .NUM_THREADS(NUM_THREADS), .PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .TID_W(TID_W)
   ) u_pcs (
      .clk(clk), .rst_n(rst_n), .reset_vector(reset_vector),
      .br_en(br_en), .br_tid(br_tid), .br_pc(br_pc),
      .adv_en(adv_en), .adv_tid(adv_tid),
      .rd_tid(sel_tid), .rd_pc(sel_pc));
endmodule

// File: rtl/thread_issue_sel_chk.sv
module thread_issue_sel_chk #(
   parameter int NUM_THREADS   = 4,
   parameter int PC_W          = 32,
   parameter int REFILL_CYCLES = 3,
   parameter int TID_W         = $clog2(NUM_THREADS)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   coarse_mode,
   input logic [NUM_THREADS-1:0] stall_vec,
   input logic [NUM_THREADS-1:0] costly_vec,
   input logic                   br_en,
   input logic [TID_W-1:0]       br_tid,
   input logic [PC_W-1:0]        br_pc,
   input logic                   sel_valid,
   input logic [TID_W-1:0]       sel_tid,
   input logic [PC_W-1:0]        sel_pc
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   function automatic logic [TID_W-1:0] succ(input logic [TID_W-1:0] t);
      return (t == TID_W'(NUM_THREADS - 1)) ? '0 : t + 1'b1;
   endfunction

   // R2
   a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !coarse_mode && !$past(coarse_mode) && $past(sel_valid) && stall_vec == '0)
      |-> (sel_valid && sel_tid == succ($past(sel_tid))));

   // R3
   a_r3_skip_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> !stall_vec[sel_tid]);

   // R4
   a_r4_all_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (&stall_vec) |-> !sel_valid);

   // R5
   a_r5_blocking_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && coarse_mode && $past(coarse_mode) && $past(sel_valid) && sel_valid)
      |-> sel_tid == $past(sel_tid));

   // R6
   a_r6_switch_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      (REFILL_CYCLES > 1 && past_ok && coarse_mode && $past(coarse_mode) && sel_tid != $past(sel_tid))
      |-> !sel_valid);

   // R7
   a_r7_costly_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
      (coarse_mode && costly_vec[sel_tid]) |-> !sel_valid);

   // R8
   a_r8_branch_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && sel_valid && $past(br_en) && $past(br_tid) == sel_tid)
      |-> sel_pc == $past(br_pc));
endmodule

bind thread_issue_sel thread_issue_sel_chk #(
   .NUM_THREADS(NUM_THREADS), .PC_W(PC_W), .REFILL_CYCLES(REFILL_CYCLES), .TID_W(TID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .coarse_mode(coarse_mode),
   .stall_vec(stall_vec), .costly_vec(costly_vec),
   .br_en(br_en), .br_tid(br_tid), .br_pc(br_pc),
   .sel_valid(sel_valid), .sel_tid(sel_tid), .sel_pc(sel_pc));

// File: tb/thread_issue_sel_test.sv
`timescale 1ns/1ps
module thread_issue_sel_test;
   localparam int N      = 4;
   localparam int PW     = 32;
   localparam int STEP   = 4;
   localparam int REFILL = 3;
   localparam logic [PW-1:0] RVEC = 32'h0000_1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          coarse_mode = 1'b0;
   logic [PW-1:0] reset_vector = RVEC;
   logic [N-1:0]  stall_vec = '1;
   logic [N-1:0]  costly_vec = '0;
   logic          br_en = 1'b0;
   logic [1:0]    br_tid = '0;
   logic [PW-1:0] br_pc = '0;
   logic          adv_en = 1'b0;
   logic [1:0]    adv_tid = '0;
   logic          sel_valid;
   logic [1:0]    sel_tid;
   logic [PW-1:0] sel_pc;

   always #4 clk = ~clk;

   thread_issue_sel #(.NUM_THREADS(N), .PC_W(PW), .INSN_BYTES(STEP), .REFILL_CYCLES(REFILL)) uut (
      .clk(clk), .rst_n(rst_n), .coarse_mode(coarse_mode), .reset_vector(reset_vector),
      .stall_vec(stall_vec), .costly_vec(costly_vec),
      .br_en(br_en), .br_tid(br_tid), .br_pc(br_pc),
      .adv_en(adv_en), .adv_tid(adv_tid),
      .sel_valid(sel_valid), .sel_tid(sel_tid), .sel_pc(sel_pc));

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [34:0] exp_q [$];
   string       tag_q [$];

   int          m_own = 0;
   int          m_cnt = 0;
   bit          m_fresh = 1;
   logic [PW-1:0] m_pc [N];

   // adv mode: 0 none, 1 follow issue, 2 manual thread
   task automatic step(input logic [N-1:0] st, input logic [N-1:0] co, input bit md,
                       input bit be, input int bt, input logic [PW-1:0] bp,
                       input int am, input int mt, input string tag);
      bit ev;
      int et;
      int base;
      @(posedge clk);
      #1;
      stall_vec = st; costly_vec = co; coarse_mode = md;
      ev = 0; et = m_own;
      if (!md) begin
         m_cnt = 0;
         base = m_fresh ? N - 1 : m_own;
         for (int k = 1; k <= N; k++) begin
            int c;
            c = (base + k) % N;
            if (!ev && !st[c]) begin ev = 1; et = c; end
         end
         if (ev) m_own = et;
      end else if (m_cnt > 0) begin
         m_cnt--;
      end else if (co[m_own]) begin
         for (int k = 1; k < N; k++) begin
            int c;
            c = (m_own + k) % N;
            if (!ev && !st[c] && !co[c]) begin ev = 1; et = c; end
         end
         if (ev) begin m_own = et; m_cnt = REFILL - 1; end
         ev = 0; et = m_own;
      end else begin
         ev = !st[m_own];
      end
      if (ev) m_fresh = 0;
      exp_q.push_back({ev, 2'(et), m_pc[et]});
      tag_q.push_back(tag);
      br_en = be; br_tid = 2'(bt); br_pc = bp;
      adv_en  = (am == 1) ? ev : (am == 2);
      adv_tid = (am == 1) ? 2'(et) : 2'(mt);
      if (be) m_pc[bt] = bp;
      if (adv_en && !(be && bt == int'(adv_tid))) m_pc[adv_tid] = m_pc[adv_tid] + STEP;
   endtask

   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [34:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (sel_valid !== e[34]) begin
            errors++;
            $display("FAIL %s valid act=%0b exp=%0b", t, sel_valid, e[34]);
         end else if (e[34] && (sel_tid !== e[33:32] || sel_pc !== e[31:0])) begin
            errors++;
            $display("FAIL %s tid/pc act=%0d/%h exp=%0d/%h", t, sel_tid, sel_pc, e[33:32], e[31:0]);
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog act=running exp=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) m_pc[i] = RVEC;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: first issue thread 0 at reset vector
      step('0, '0, 0, 0, 0, 0, 1, 0, "R1");
      // R2: plain rotation
      for (int i = 0; i < 7; i++) step('0, '0, 0, 0, 0, 0, 1, 0, "R2");
      // R3: thread 2 stalled, then 0 and 2
      for (int i = 0; i < 6; i++) step(4'b0100, '0, 0, 0, 0, 0, 1, 0, "R3");
      for (int i = 0; i < 4; i++) step(4'b0101, '0, 0, 0, 0, 0, 1, 0, "R3");
      // R4: all stalled, pointer holds
      step('1, '0, 0, 0, 0, 0, 1, 0, "R4");
      step('1, '0, 0, 0, 0, 0, 1, 0, "R4");
      for (int i = 0; i < 3; i++) step('0, '0, 0, 0, 0, 0, 1, 0, "R4");
      // R8: branch on thread 1, branch wins over advance on thread 3
      step('0, '0, 0, 1, 1, 32'h0000_8000, 0, 0, "R8");
      step('0, '0, 0, 1, 3, 32'h0000_C000, 2, 3, "R8");
      step('0, '0, 0, 0, 0, 0, 2, 2, "R8");
      for (int i = 0; i < 4; i++) step('0, '0, 0, 0, 0, 0, 0, 0, "R8");
      // R5: blocking mode holds thread; own short stall is a bubble
      for (int i = 0; i < 3; i++) step('0, '0, 1, 0, 0, 0, 1, 0, "R5");
      step(4'(1 << m_own), '0, 1, 0, 0, 0, 1, 0, "R5");
      for (int i = 0; i < 2; i++) step('0, '0, 1, 0, 0, 0, 1, 0, "R5");
      // R6: costly event, next thread stalled so skip one; refill bubbles
      step(4'(1 << ((m_own + 1) % N)), 4'(1 << m_own), 1, 0, 0, 0, 1, 0, "R6");
      for (int i = 0; i < REFILL + 2; i++) step('0, '0, 1, 0, 0, 0, 1, 0, "R6");
      // R7: costly with all others stalled: no switch
      step(~4'(1 << m_own), 4'(1 << m_own), 1, 0, 0, 0, 1, 0, "R7");
      for (int i = 0; i < 2; i++) step('0, '0, 1, 0, 0, 0, 1, 0, "R7");
      // R2: back to interleave
      for (int i = 0; i < 5; i++) step('0, '0, 0, 0, 0, 0, 1, 0, "R2");
      @(posedge clk);
      @(negedge clk);
      #1;
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule